// File: doc/BRIEF.md
# Hashed Bucket Exact-Match Lookup Engine

This block answers one question per request: is a given 32-bit key present in a table held in on-chip memory, and if so, which result code belongs to it. The key is folded by XOR into a short bucket index. A bucket-head memory, indexed by that bucket, holds a pointer to the first entry of a chained list. A pointer of zero means the bucket is empty. Each entry in the entry memory carries a full stored key, a result code and a pointer to the next entry, where zero ends the chain.

A request enters through a valid/ready handshake. The engine walks the chain one memory read per cycle and compares the full key at each entry. It returns hit or miss, an error flag and the result code through a second valid/ready handshake. A lookup that lands on the first entry of its bucket completes after two memory reads. A hop limit stops walks through corrupted or cyclic chains. The table is filled through two plain write ports, one per memory. Deciding where entries go is left to the agent that drives those ports.

Top module: `hash_exact_lookup`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1 and `rsp_valid` is 0.
- R2: The bucket index of a key is the XOR of its four bytes (key[31:24] ^ key[23:16] ^ key[15:8] ^ key[7:0]). The lookup starts from the pointer that the head write port last stored at that index. Entries written through the entry port are seen by every later lookup.
- R3: If the head pointer is 0, the response is a miss with the error flag clear. `rsp_valid` first reads high one clock edge after the accepting edge.
- R4: Entries are compared on the full 32-bit key, in chain order. The first equal entry gives a hit carrying that entry's 8-bit result. When the match is the n-th entry, `rsp_valid` first reads high 1+n edges after the accepting edge, so a first-entry hit takes 2 edges.
- R5: If the chain reaches an entry whose next pointer is 0 without an equal key, and within the hop limit, the response is a miss with the error flag clear.
- R6: At most 8 entries are read per lookup. If the 8th entry is unequal and its next pointer is nonzero, the response is a miss with the error flag set, 9 edges after acceptance. A match at the 8th entry is still a hit. Hit and error never appear together.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and `req_ready` stays low. Requests are not taken while a lookup is in progress.
- R8: After a response is taken (`rsp_valid` and `rsp_ready` both high at an edge), `rsp_valid` is low and `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_we | input | 1 | Write strobe for the bucket-head memory |
| head_waddr | input | 8 | Bucket index to write |
| head_wdata | input | 6 | First-entry pointer for that bucket (0 = empty) |
| ent_we | input | 1 | Write strobe for the entry memory |
| ent_waddr | input | 6 | Entry address to write (address 0 is reserved) |
| ent_wkey | input | 32 | Stored full key |
| ent_wres | input | 8 | Stored result code |
| ent_wnext | input | 6 | Next-entry pointer (0 = end of chain) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_key | input | 32 | Key to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Key found |
| rsp_err | output | 1 | Hop limit exceeded |
| rsp_result | output | 8 | Result code of the matching entry |

## Verification
The bench builds the engine with its default parameters. These give 256 buckets, 63 usable entry slots and a hop limit of 8. The entry memory is small enough that a random fill of 40 keys, half of them steered into two hot buckets, creates chains longer than the hop limit. Random lookups therefore reach hits deep in a chain, misses at the end of a chain, and error misses in the same run. Directed cases pin down the exact latency of an empty bucket, a first-entry hit, a hit at the 8th entry and a bound overrun. They also cover a self-looping chain and a response held under backpressure.

// File: rtl/hel_pkg.sv
// Package: shared types of the hashed exact-match lookup engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package hel_pkg;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_WALK = 2'd2,
        ST_RESP = 2'd3
    } walk_state_t;

endpackage

// File: rtl/hel_fold.sv
// Module: hel_fold
// Folds a KEY_W-bit key to a Q-bit bucket index by XOR of Q-bit slices.
// The key is zero-extended to a whole number of slices. The module is purely combinational.
module hel_fold #(
    parameter int KEY_W = 32,
    parameter int Q     = 8
) (
    input  logic [KEY_W-1:0] key,
    output logic [Q-1:0]     bucket
);
    localparam int NSL = (KEY_W + Q - 1) / Q;
    localparam int PW  = NSL * Q;

    logic [PW-1:0] padded;
    logic [Q-1:0]  slice [NSL];

    assign padded = PW'(key);

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign slice[g] = padded[g*Q +: Q];
    end

    // XOR every slice together into the bucket index
    always_comb begin
        bucket = '0;
        for (int i = 0; i < NSL; i++) begin
            bucket = bucket ^ slice[i];
        end
    end
endmodule

// File: rtl/hel_ram.sv
// Module: hel_ram
// Simple dual-port memory with one write port and one synchronous read port.
// Read data appears one cycle after a read enable. A read of an address written
// in the same cycle returns the old word. Contents are not reset.
module hel_ram #(
    parameter int W  = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store a word on a write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the addressed word on a read enable
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/hash_exact_lookup.sv
// Module: hash_exact_lookup (top)
// Exact-match lookup of a key through XOR-fold hashing, a bucket-head memory
// and chained entries. One lookup is in flight at a time. Head pointer 0 means
// an empty bucket, next pointer 0 ends a chain, and entry address 0 is reserved.
// The walk reads at most MAX_HOPS entries before it reports a miss with an error.
// Assumes the table is written only while the engine is idle.
module hash_exact_lookup #(
    parameter int KEY_W    = 32,
    parameter int Q        = 8,
    parameter int PTR_W    = 6,
    parameter int RES_W    = 8,
    parameter int MAX_HOPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_we,
    input  logic [Q-1:0]     head_waddr,
    input  logic [PTR_W-1:0] head_wdata,
    input  logic             ent_we,
    input  logic [PTR_W-1:0] ent_waddr,
    input  logic [KEY_W-1:0] ent_wkey,
    input  logic [RES_W-1:0] ent_wres,
    input  logic [PTR_W-1:0] ent_wnext,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [KEY_W-1:0] req_key,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_hit,
    output logic             rsp_err,
    output logic [RES_W-1:0] rsp_result
);
    import hel_pkg::*;

    localparam int EW = KEY_W + RES_W + PTR_W;
    localparam int HW = $clog2(MAX_HOPS + 1);
    localparam logic [HW-1:0] HOP_LIM = HW'(MAX_HOPS);

    walk_state_t      state_q;
    logic [KEY_W-1:0] key_q;
    logic [HW-1:0]    hops_q;
    logic [Q-1:0]     bucket;
    logic             head_re;
    logic [PTR_W-1:0] head_rdata;
    logic             ent_re;
    logic [PTR_W-1:0] ent_raddr;
    logic [EW-1:0]    ent_rdata;
    logic [KEY_W-1:0] e_key;
    logic [RES_W-1:0] e_res;
    logic [PTR_W-1:0] e_next;
    logic             e_match;
    logic             e_last;
    logic             e_limit;

    assign {e_key, e_res, e_next} = ent_rdata;
    assign e_match = (e_key == key_q);
    assign e_last  = (e_next == '0);
    assign e_limit = (hops_q == HOP_LIM);

    hel_fold #(.KEY_W(KEY_W), .Q(Q)) u_fold (
        .key    (req_key),
        .bucket (bucket)
    );

    hel_ram #(.W(PTR_W), .AW(Q)) u_head_mem (
        .clk   (clk),
        .we    (head_we),
        .waddr (head_waddr),
        .wdata (head_wdata),
        .re    (head_re),
        .raddr (bucket),
        .rdata (head_rdata)
    );

    hel_ram #(.W(EW), .AW(PTR_W)) u_ent_mem (
        .clk   (clk),
        .we    (ent_we),
        .waddr (ent_waddr),
        .wdata ({ent_wkey, ent_wres, ent_wnext}),
        .re    (ent_re),
        .raddr (ent_raddr),
        .rdata (ent_rdata)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // Choose which memory to read this cycle and at which address
    always_comb begin
        head_re   = (state_q == ST_IDLE) && req_valid;
        ent_re    = 1'b0;
        ent_raddr = head_rdata;
        case (state_q)
            ST_HEAD: begin
                ent_re    = (head_rdata != '0);
                ent_raddr = head_rdata;
            end
            ST_WALK: begin
                ent_re    = !e_match && !e_last && !e_limit;
                ent_raddr = e_next;
            end
            default: ;
        endcase
    end

    // Walk controller: accept, read head, follow chain, hold response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            key_q      <= '0;
            hops_q     <= '0;
            rsp_hit    <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_result <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        key_q   <= req_key;
                        state_q <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    hops_q <= HW'(1);
                    if (head_rdata == '0) begin
                        rsp_hit    <= 1'b0;
                        rsp_err    <= 1'b0;
                        rsp_result <= '0;
                        state_q    <= ST_RESP;
                    end else begin
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (e_match) begin
                        rsp_hit    <= 1'b1;
                        rsp_err    <= 1'b0;
                        rsp_result <= e_res;
                        state_q    <= ST_RESP;
                    end else if (e_last || e_limit) begin
                        rsp_hit    <= 1'b0;
                        rsp_err    <= !e_last;
                        rsp_result <= '0;
                        state_q    <= ST_RESP;
                    end else begin
                        hops_q <= hops_q + HW'(1);
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hash_exact_lookup_chk.sv
// Module: hash_exact_lookup_chk
// Protocol and timing checker for hash_exact_lookup, attached by bind.
// It counts edges from acceptance to the response with a local counter.
module hash_exact_lookup_chk #(
    parameter int RES_W    = 8,
    parameter int MAX_HOPS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_hit,
    input logic             rsp_err,
    input logic [RES_W-1:0] rsp_result
);
    logic [7:0] lat_q;

    // Count edges since acceptance until the response shows up
    always_ff @(posedge clk) begin
        if (!rst_n)                       lat_q <= '0;
        else if (req_valid && req_ready)  lat_q <= 8'd1;
        else if (rsp_valid && rsp_ready)  lat_q <= '0;
        else if (lat_q != '0 && !rsp_valid) lat_q <= lat_q + 8'd1;
    end

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
            && $stable(rsp_err) && $stable(rsp_result)));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R6
    hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_err));

    // R8
    rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

    // R6
    latency_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (lat_q >= 8'd2 && lat_q <= 8'(MAX_HOPS + 2)));
endmodule

bind hash_exact_lookup hash_exact_lookup_chk #(.RES_W(RES_W), .MAX_HOPS(MAX_HOPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_hit    (rsp_hit),
    .rsp_err    (rsp_err),
    .rsp_result (rsp_result)
);

// File: tb/tb_hash_exact_lookup.sv
module tb_hash_exact_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int HOPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_we = 1'b0;
    logic [7:0]  head_waddr = '0;
    logic [5:0]  head_wdata = '0;
    logic        ent_we = 1'b0;
    logic [5:0]  ent_waddr = '0;
    logic [31:0] ent_wkey = '0;
    logic [7:0]  ent_wres = '0;
    logic [5:0]  ent_wnext = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_key = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_hit;
    logic        rsp_err;
    logic [7:0]  rsp_result;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    // Bench-side table model
    int          m_head [256];
    logic [31:0] m_key  [64];
    logic [7:0]  m_res  [64];
    int          m_next [64];

    hash_exact_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .head_we(head_we), .head_waddr(head_waddr), .head_wdata(head_wdata),
        .ent_we(ent_we), .ent_waddr(ent_waddr), .ent_wkey(ent_wkey),
        .ent_wres(ent_wres), .ent_wnext(ent_wnext),
        .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_result(rsp_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_err++;
                $display("FAIL R8 watchdog expired actual=%0d expected=<100000", cycles);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    function automatic logic [7:0] bkt(input logic [31:0] k);
        return k[31:24] ^ k[23:16] ^ k[15:8] ^ k[7:0];
    endfunction

    // Expected outcome from the requirements: {hit, err, result}, plus edge count
    function automatic logic [9:0] expect_of(input logic [31:0] k, output int lat);
        int p = m_head[bkt(k)];
        lat = 1;
        if (p == 0) return 10'd0;
        for (int h = 1; h <= HOPS; h++) begin
            lat = 1 + h;
            if (m_key[p] == k) return {1'b1, 1'b0, m_res[p]};
            if (m_next[p] == 0) return 10'd0;
            if (h == HOPS) return {1'b0, 1'b1, 8'd0};
            p = m_next[p];
        end
        return 10'd0;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr_head(input int b, input int p);
        @(negedge clk);
        head_we = 1'b1; head_waddr = 8'(b); head_wdata = 6'(p);
        @(negedge clk);
        head_we = 1'b0;
        m_head[b] = p;
    endtask

    task automatic wr_ent(input int p, input logic [31:0] k, input logic [7:0] r, input int nx);
        @(negedge clk);
        ent_we = 1'b1; ent_waddr = 6'(p); ent_wkey = k; ent_wres = r; ent_wnext = 6'(nx);
        @(negedge clk);
        ent_we = 1'b0;
        m_key[p] = k; m_res[p] = r; m_next[p] = nx;
    endtask

    task automatic clear_heads();
        for (int b = 0; b < 256; b++) wr_head(b, 0);
    endtask

    // Run one lookup; returns packed {hit, err, result} and edges until response
    task automatic lookup(input logic [31:0] k, input int hold, output logic [9:0] got, output int lat);
        logic [9:0] snap;
        @(negedge clk);
        req_valid = 1'b1; req_key = k; rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        got = {rsp_hit, rsp_err, rsp_hit ? rsp_result : 8'd0};
        snap = {rsp_hit, rsp_err, rsp_result};
        for (int h = 0; h < hold; h++) begin
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid && !req_ready && ({rsp_hit, rsp_err, rsp_result} == snap),
                "R7 hold", {rsp_valid, req_ready, rsp_hit, rsp_err, rsp_result},
                {2'b10, snap});
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8 release", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic run_case(input logic [31:0] k, input int hold, input string rq, input int want_lat);
        logic [9:0] got, exp;
        int lat, elat;
        exp = expect_of(k, elat);
        lookup(k, hold, got, lat);
        chk(got == exp, rq, got, exp);
        if (want_lat > 0) chk(lat == want_lat, rq, lat, want_lat);
        else chk(lat == elat, rq, lat, elat);
    endtask

    initial begin
        logic [31:0] k;
        void'($urandom(32'd7331));
        for (int i = 0; i < 256; i++) m_head[i] = 0;
        for (int i = 0; i < 64; i++) begin m_key[i] = '0; m_res[i] = '0; m_next[i] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid, "R1 reset", {req_ready, rsp_valid}, 2'b10);

        clear_heads();

        // R3 empty bucket 0x44
        run_case(32'h1122_3344, 0, "R3 empty", 1);

        // R2/R4 single entry in bucket A5
        wr_ent(1, 32'h0000_00A5, 8'h5C, 0);
        wr_head(8'hA5, 1);
        run_case(32'h0000_00A5, 0, "R4 first hit", 2);
        // R5 same bucket, absent key
        run_case(32'h0000_01A4, 0, "R5 end miss", 2);

        // R4 collision: second entry in front of the first
        wr_ent(2, 32'h0000_01A4, 8'h77, 1);
        wr_head(8'hA5, 2);
        run_case(32'h0000_00A5, 0, "R4 second hit", 3);
        run_case(32'h0000_01A4, 1, "R2 updated head", 2);

        // R6 eight-entry chain in bucket 0x10
        for (int i = 1; i <= 9; i++) begin
            k = {8'(i), 16'h0000, 8'(8'h10 ^ 8'(i))};
            wr_ent(9 + i, k, 8'(8'h80 + i), (i < 8) ? 10 + i : 0);
        end
        wr_head(8'h10, 10);
        run_case({8'd8, 16'h0000, 8'h18}, 0, "R6 eighth hit", 9);
        run_case(32'h2000_0030, 0, "R5 full chain miss", 9);
        wr_ent(17, {8'd8, 16'h0000, 8'h18}, 8'h88, 18);
        run_case({8'd9, 16'h0000, 8'h19}, 0, "R6 bound err", 9);
        run_case({8'd8, 16'h0000, 8'h18}, 2, "R6 eighth still hit", 9);

        // R6 self loop in bucket 0x20
        wr_ent(30, 32'h0000_0020, 8'h42, 30);
        wr_head(8'h20, 30);
        run_case(32'h0000_2000, 0, "R6 cycle err", 9);
        run_case(32'h0000_0020, 3, "R7 backpressure hit", 2);

        // Random phase with two hot buckets
        clear_heads();
        for (int i = 1; i <= 40; i++) begin
            logic [7:0] tgt;
            k = $urandom;
            if (i % 2 == 1) begin
                tgt = ($urandom % 2 == 0) ? 8'h3C : 8'h3D;
                k[7:0] = k[7:0] ^ bkt(k) ^ tgt;
            end
            wr_ent(i, k, 8'($urandom), m_head[bkt(k)]);
            wr_head(bkt(k), i);
        end
        for (int n = 0; n < 120; n++) begin
            int sel = $urandom % 10;
            if (sel < 6) k = m_key[1 + ($urandom % 40)];
            else begin
                k = $urandom;
                if (sel < 8) k[7:0] = k[7:0] ^ bkt(k) ^ 8'h3C;
            end
            run_case(k, $urandom % 3, "R4 random", 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule